// File: doc/BRIEF.md
# Per-Vector Interrupt Moderation Timer

This block limits how often interrupt messages go out. It holds sixteen countdown timers, one for each message vector. Each timer has an interval register, written by software, that counts in steps of a 256 ns tick. A prescaler builds that tick from the clock, and the clock period is set by a parameter. A table of 24 entries sends each interrupt cause to one vector.

A cause pulse marks its vector as pending. The vector then waits until its timer has reached zero. At that point the block raises a one-cycle message request for the vector, clears the pending state and reloads the timer from the interval register. An interval of zero turns throttling off for that vector.

With vector mode off, every cause is folded onto timer 0. In that mode the result appears on a single legacy interrupt pulse and not on the per-vector requests.

Top module: `irq_pace_timer`

## Requirements
- R1: During and after reset, `msg_req` and `legacy_irq` are low. All intervals and all timers are 0, and every cause maps to vector 0.
- R2: A shared accumulator adds `CLK_NS` each cycle and emits one tick whenever the sum reaches 256. The tick is 256 ns on average.
- R3: A pulse on `cause_evt[c]` sets the pending state of the vector held in table entry `c`, a 4-bit vector number. A write on `map_we` stores `map_vec` at entry `map_cause` and is used from the next cycle onward.
- R4: Take a clock edge at which vector v is pending, its timer reads 0, and vector mode is on. In the cycle after that edge, `msg_req[v]` (bit v = vector v) is high for exactly that cycle.
- R5: At the firing edge, the vector's pending state clears and its timer loads the programmed interval. On each tick a nonzero timer drops by one. A timer at zero stays at zero.
- R6: With a nonzero interval I, the time between two messages of the same vector is more than (I-1)*256 ns. At least I ticks separate the two messages.
- R7: With an interval of 0, a cause presented in cycle k gives a request in cycle k+2.
- R8: A cause for vector v that arrives in the same cycle that v fires leaves v pending. The next message then follows after the interval.
- R9: With `vec_mode` low, every cause feeds vector 0 with timer 0, a firing shows as a one-cycle `legacy_irq`, and `msg_req` stays all zero. With `vec_mode` high, `legacy_irq` stays low.
- R10: A write on `cfg_we` stores `cfg_ival` as the interval of vector `cfg_vec`. It changes only later reloads and does not change a count already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_mode | input | 1 | 1: per-vector messages, 0: single legacy output on timer 0 |
| cfg_we | input | 1 | Interval register write strobe |
| cfg_vec | input | 4 | Vector whose interval is written |
| cfg_ival | input | 12 | Interval value in 256 ns ticks |
| map_we | input | 1 | Cause-to-vector table write strobe |
| map_cause | input | 5 | Table entry written |
| map_vec | input | 4 | Vector number stored in the entry |
| cause_evt | input | 24 | One pulse per cause event |
| msg_req | output | 16 | One-cycle message request per vector |
| legacy_irq | output | 1 | One-cycle interrupt pulse in legacy mode |

## Verification
Two functions can land in the same clock edge. One is a vector firing, which clears its pending state. The other is a new cause for that same vector, which sets it again. The bench provokes this by holding one cause high for a long stretch, so every firing edge of its vector also carries a new event. The reference model then expects a second message no sooner than the interval allows, and this is checked against the request outputs cycle by cycle. Table writes that coincide with causes, and interval writes during a running count, are mixed into the same run and judged by the same comparison.

// File: rtl/irq_pace_timer.sv
module irq_pace_timer #(
  parameter int NVEC    = 16,
  parameter int NCAUSE  = 24,
  parameter int IVAL_W  = 12,
  parameter int CLK_NS  = 10,
  parameter int TICK_NS = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vec_mode,
  input  logic                      cfg_we,
  input  logic [$clog2(NVEC)-1:0]   cfg_vec,
  input  logic [IVAL_W-1:0]         cfg_ival,
  input  logic                      map_we,
  input  logic [$clog2(NCAUSE)-1:0] map_cause,
  input  logic [$clog2(NVEC)-1:0]   map_vec,
  input  logic [NCAUSE-1:0]         cause_evt,
  output logic [NVEC-1:0]           msg_req,
  output logic                      legacy_irq
);
  localparam int VW    = $clog2(NVEC);
  localparam int ACC_W = $clog2(TICK_NS + CLK_NS) + 1;

  logic [ACC_W-1:0]  acc, acc_sum;
  logic              tick;
  logic [IVAL_W-1:0] ival [NVEC];
  logic [IVAL_W-1:0] cnt  [NVEC];
  logic [VW-1:0]     cmap [NCAUSE];
  logic [NVEC-1:0]   pend, hit, fire;

  assign acc_sum = acc + ACC_W'(CLK_NS);
  assign tick    = acc_sum >= ACC_W'(TICK_NS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) acc <= '0;
    else        acc <= tick ? acc_sum - ACC_W'(TICK_NS) : acc_sum;

  always_comb begin
    hit = '0;
    for (int c = 0; c < NCAUSE; c++)
      if (cause_evt[c])
        hit[vec_mode ? cmap[c] : '0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      for (int c = 0; c < NCAUSE; c++) cmap[c] <= '0;
    else if (map_we)
      cmap[map_cause] <= map_vec;

  genvar v;
  generate
    for (v = 0; v < NVEC; v++) begin : g_vec
      assign fire[v] = pend[v] && cnt[v] == '0 && (vec_mode || v == 0);

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ival[v] <= '0;
          cnt[v]  <= '0;
          pend[v] <= 1'b0;
        end else begin
          if (cfg_we && cfg_vec == VW'(v)) ival[v] <= cfg_ival;
          pend[v] <= (pend[v] && !fire[v]) || hit[v];
          if (fire[v])                    cnt[v] <= ival[v];
          else if (tick && cnt[v] != '0)  cnt[v] <= cnt[v] - 1'b1;
        end

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) msg_req[v] <= 1'b0;
        else        msg_req[v] <= fire[v] && vec_mode;

      AST_FIRE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req[v] |-> $past(pend[v]) && $past(cnt[v]) == '0); // R4
      AST_PEND_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req[v] |-> pend[v] == $past(hit[v])); // R8
      AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fire[v]) |-> cnt[v] == $past(cnt[v]) || cnt[v] == $past(cnt[v]) - 1'b1); // R5
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) legacy_irq <= 1'b0;
    else        legacy_irq <= fire[0] && !vec_mode;

  AST_LEG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vec_mode) |-> !legacy_irq); // R9
  AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vec_mode) |-> msg_req == '0); // R9
  AST_LEG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_irq |-> $past(pend[0]) && $past(cnt[0]) == '0); // R9
endmodule

// File: tb/tb_irq_pace_timer.sv
module tb_irq_pace_timer;
  logic        clk = 0, rst_n = 0, vec_mode = 1;
  logic        cfg_we = 0, map_we = 0;
  logic [3:0]  cfg_vec = 0, map_vec = 0;
  logic [11:0] cfg_ival = 0;
  logic [4:0]  map_cause = 0;
  logic [23:0] cause_evt = 0;
  logic [15:0] msg_req;
  logic        legacy_irq;

  irq_pace_timer dut (.clk, .rst_n, .vec_mode, .cfg_we, .cfg_vec, .cfg_ival,
    .map_we, .map_cause, .map_vec, .cause_evt, .msg_req, .legacy_irq);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  string phase = "R1";

  int m_acc, m_ival[16], m_cnt[16], m_map[24], m_load[16];
  bit m_pend[16], m_req[16], m_leg, m_f[16], m_nev[16], m_tk;
  int last_fire[16], last_load[16];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_leg = 0;
      for (int i = 0; i < 16; i++) begin
        m_ival[i] = 0; m_cnt[i] = 0; m_pend[i] = 0; m_req[i] = 0; m_load[i] = 0;
      end
      for (int i = 0; i < 24; i++) m_map[i] = 0;
    end else begin
      for (int i = 0; i < 16; i++) begin
        m_f[i] = m_pend[i] && m_cnt[i] == 0 && (vec_mode || i == 0);
        m_nev[i] = 0;
      end
      m_acc += 10;
      m_tk = m_acc >= 256;
      if (m_tk) m_acc -= 256;
      for (int c = 0; c < 24; c++)
        if (cause_evt[c]) m_nev[vec_mode ? m_map[c] : 0] = 1;
      for (int i = 0; i < 16; i++) begin
        m_req[i] = m_f[i] && vec_mode;
        if (m_f[i]) begin
          m_pend[i] = m_nev[i];
          m_cnt[i] = m_ival[i];
          m_load[i] = m_ival[i];
        end else begin
          m_pend[i] = m_pend[i] || m_nev[i];
          if (m_tk && m_cnt[i] > 0) m_cnt[i]--;
        end
      end
      m_leg = m_f[0] && !vec_mode;
      if (cfg_we) m_ival[cfg_vec] = cfg_ival;
      if (map_we) m_map[map_cause] = map_vec;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int exp_v;
      exp_v = 0;
      for (int i = 0; i < 16; i++) if (m_req[i]) exp_v |= (1 << i);
      chk(msg_req == 16'(exp_v), phase, msg_req, exp_v);
      chk(legacy_irq == m_leg, "R9", legacy_irq, m_leg);
      for (int i = 0; i < 16; i++)
        if (msg_req[i]) begin
          if (last_fire[i] > 0 && last_load[i] > 0)
            chk((cyc - last_fire[i]) * 10 > (last_load[i] - 1) * 256, "R6",
                cyc - last_fire[i], last_load[i]);
          last_fire[i] = cyc;
          last_load[i] = m_load[i];
        end
    end
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog cyc=%0d actual=1 expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic setival(input int v, input int val);
    @(negedge clk); cfg_we = 1; cfg_vec = 4'(v); cfg_ival = 12'(val);
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic setmap(input int c, input int v);
    @(negedge clk); map_we = 1; map_cause = 5'(c); map_vec = 4'(v);
    @(negedge clk); map_we = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin last_fire[i] = 0; last_load[i] = 0; end
    repeat (3) @(negedge clk);
    chk(msg_req == 0, "R1", msg_req, 0);
    chk(legacy_irq == 0, "R1", legacy_irq, 0);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    @(negedge clk); cause_evt[9] = 1;
    @(negedge clk); cause_evt[9] = 0;
    @(negedge clk);
    chk(msg_req == 16'h0001, "R1", msg_req, 1);
    phase = "R3";
    setival(1, 3); setival(2, 0); setival(5, 2); setival(15, 1);
    setmap(3, 1); setmap(7, 2); setmap(10, 5); setmap(23, 15);
    phase = "R7";
    @(negedge clk); cause_evt[7] = 1;
    @(negedge clk); cause_evt[7] = 0;
    @(negedge clk);
    chk(msg_req == 16'h0004, "R7", msg_req, 4);
    phase = "R4";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      for (int c = 0; c < 24; c++) cause_evt[c] = ($urandom % 40) == 0;
      map_we = ($urandom % 300) == 0;
      map_cause = 5'($urandom % 24); map_vec = 4'($urandom % 16);
      cfg_we = ($urandom % 500) == 0;
      cfg_vec = 4'($urandom % 16); cfg_ival = 12'($urandom % 5);
      phase = (k % 2) ? "R5" : "R10";
    end
    @(negedge clk); cause_evt = 0; map_we = 0; cfg_we = 0;
    phase = "R8";
    setival(1, 3); setmap(3, 1);
    @(negedge clk); cause_evt[3] = 1;
    repeat (1500) @(negedge clk);
    cause_evt[3] = 0;
    repeat (200) @(negedge clk);
    phase = "R2";
    setival(4, 6); setmap(0, 4);
    @(negedge clk); cause_evt[0] = 1;
    repeat (600) @(negedge clk);
    cause_evt[0] = 0;
    repeat (300) @(negedge clk);
    phase = "R9";
    vec_mode = 0; setival(0, 2);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      for (int c = 0; c < 24; c++) cause_evt[c] = ($urandom % 60) == 0;
    end
    @(negedge clk); cause_evt = 0;
    repeat (200) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule